// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns a single burst request into the sequence of per-beat addresses that a memory-mapped master or slave needs. A request carries a start address, an encoded length (beats minus one), an encoded beat size (log2 of bytes per beat) and a burst kind. When the request is accepted, the block presents the first beat's address, a beat index and a final-beat indication. It then steps to the next beat on every advance strobe, which is normally tied to a completed VALID/READY handshake on the data channel.

Incrementing bursts step by the beat size and are checked for crossing a 4 KB page. Wrapping bursts stay inside a window whose size is the burst's total byte count, aligned to that size. Fixed bursts repeat the start address. Requests that break a rule are refused: the error flag rises and no burst starts.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy_o, err_o and last_o are 0, and addr_o and beat_o are 0.
- R2: A start_i pulse while busy_o is 0 with a legal request makes busy_o 1 in the next cycle, with addr_o equal to the start address and beat_o equal to 0. Each advance_i while busy increments beat_o by one. The advance taken at beat_o equal to len_i clears busy_o, so a burst lasts len_i+1 beats.
- R3: last_o is 1 exactly when busy_o is 1 and beat_o equals the accepted len_i.
- R4: With burst_i = 01 (incrementing), beat n ≥ 1 has the address A + n·2^size_i, where A is the start address rounded down to a multiple of 2^size_i.
- R5: With burst_i = 10 (wrapping), let W = (len_i+1)·2^size_i and L = A rounded down to a multiple of W. Beat n ≥ 1 has the address L + ((A − L + n·2^size_i) mod W).
- R6: With burst_i = 00 (fixed), every beat has the start address.
- R7: A request is refused when burst_i = 11, when a wrapping request has len_i other than 1, 3, 7 or 15, or when an incrementing request's last byte, A + (len_i+1)·2^size_i − 1, lies in a different 4 KB page (address bits above bit 11, including a carry past the top) than the start address. A refused start sets err_o to 1 and leaves busy_o 0. err_o holds until the next start taken while idle, which sets it to that request's verdict.
- R8: start_i while busy_o is 1 is ignored, including in the cycle of the final advance. The burst continues with its original addresses, and err_o is unchanged.
- R9: advance_i while busy_o is 0 has no effect, and addr_o and beat_o hold their values while no advance or accepted start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| start_addr_i | input | ADDR_W | Start address of the request |
| len_i | input | LEN_W | Beats minus one |
| size_i | input | SIZE_W | log2 of bytes per beat |
| burst_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| advance_i | input | 1 | Beat accepted; step to next beat |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | LEN_W | Index of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | The most recent idle start was refused |

## Verification
The two functions that can meet in one cycle are the final-beat advance, which ends a burst, and a new start request, which could begin another. The bench raises start_i with a different address in the very cycle of every final advance, and also together with an ordinary advance partway through each burst. It judges the result by requiring busy_o to fall, err_o to stay unchanged and every remaining beat to follow the original request's address sequence, all computed arithmetically over a sweep of every burst kind, every beat size, several lengths and start addresses near page and address-space edges.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      BT_FIXED = 2'b00,
      BT_INCR  = 2'b01,
      BT_WRAP  = 2'b10,
      BT_RSVD  = 2'b11
   } burst_e;
endpackage

// File: rtl/bag_check.sv
module bag_check
   import bag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 8,
   parameter int SIZE_W    = 3,
   parameter int PAGE_BITS = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SIZE_W-1:0] size_i,
   input  burst_e            kind_i,
   output logic              bad_o
);
   localparam int XW = ADDR_W + 1;

   logic [XW-1:0] stride_x, base_x, end_x;
   logic          page_cross, wrap_len_ok;

   always_comb begin
      stride_x   = XW'(1) << size_i;
      base_x     = {1'b0, addr_i} & ~(stride_x - XW'(1));
      end_x      = base_x + ((XW'(len_i) + XW'(1)) << size_i) - XW'(1);
      page_cross = end_x[XW-1:PAGE_BITS] != {1'b0, addr_i[ADDR_W-1:PAGE_BITS]};
      wrap_len_ok = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                    (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
      unique case (kind_i)
         BT_FIXED: bad_o = 1'b0;
         BT_INCR:  bad_o = page_cross;
         BT_WRAP:  bad_o = !wrap_len_ok;
         default:  bad_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/bag_next.sv
module bag_next
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int SIZE_W = 3
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SIZE_W-1:0] size_i,
   input  burst_e            kind_i,
   output logic [ADDR_W-1:0] nxt_o
);
   logic [ADDR_W-1:0] stride, base, stepped, win_mask;

   always_comb begin
      stride   = ADDR_W'(1) << size_i;
      base     = cur_i & ~(stride - ADDR_W'(1));
      stepped  = base + stride;
      win_mask = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
      unique case (kind_i)
         BT_INCR: nxt_o = stepped;
         BT_WRAP: nxt_o = (cur_i & ~win_mask) | (stepped & win_mask);
         default: nxt_o = cur_i;
      endcase
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 8,
   parameter int SIZE_W    = 3,
   parameter int PAGE_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [1:0]        burst_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  beat_o,
   output logic              last_o,
   output logic              busy_o,
   output logic              err_o
);
   localparam int MAX_SPAN_BITS = LEN_W + (1 << SIZE_W);

   generate
      if (ADDR_W <= PAGE_BITS) begin : g_bad_page
         $error("burst_addr_gen: ADDR_W must exceed PAGE_BITS");
      end
      if (ADDR_W < MAX_SPAN_BITS) begin : g_bad_span
         $error("burst_addr_gen: ADDR_W too narrow for largest burst span");
      end
   endgenerate

   logic              busy_q, err_q;
   logic [ADDR_W-1:0] addr_q, addr_nxt;
   logic [LEN_W-1:0]  beat_q, len_q;
   logic [SIZE_W-1:0] size_q;
   burst_e            kind_q;
   logic              req_bad, take, step, finish;

   bag_check #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .PAGE_BITS(PAGE_BITS)
   ) i_check (
      .addr_i (start_addr_i),
      .len_i  (len_i),
      .size_i (size_i),
      .kind_i (burst_e'(burst_i)),
      .bad_o  (req_bad)
   );

   bag_next #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
   ) i_next (
      .cur_i  (addr_q),
      .len_i  (len_q),
      .size_i (size_q),
      .kind_i (kind_q),
      .nxt_o  (addr_nxt)
   );

   assign take   = start_i && !busy_q;
   assign step   = advance_i && busy_q;
   assign finish = step && (beat_q == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         addr_q <= '0;
         beat_q <= '0;
         len_q  <= '0;
         size_q <= '0;
         kind_q <= BT_FIXED;
      end else if (take) begin
         err_q <= req_bad;
         if (!req_bad) begin
            busy_q <= 1'b1;
            addr_q <= start_addr_i;
            beat_q <= '0;
            len_q  <= len_i;
            size_q <= size_i;
            kind_q <= burst_e'(burst_i);
         end
      end else if (step) begin
         if (finish) begin
            busy_q <= 1'b0;
         end else begin
            beat_q <= beat_q + LEN_W'(1);
            addr_q <= addr_nxt;
         end
      end
   end

   assign addr_o = addr_q;
   assign beat_o = beat_q;
   assign busy_o = busy_q;
   assign err_o  = err_q;
   assign last_o = busy_q && (beat_q == len_q);

   logic [ADDR_W-1:0] beat_mask;
   assign beat_mask = (ADDR_W'(1) << size_q) - ADDR_W'(1);

   a_r2_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> beat_o <= len_q);
   a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && last_o) |=> !busy_o);
   a_r4_aligned_beats: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && beat_o != '0 && kind_q != BT_FIXED) |-> (addr_o & beat_mask) == '0);
   a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && kind_q == BT_FIXED && advance_i && !last_o) |=> $stable(addr_o));
   a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o);
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !advance_i) |=> busy_o && $stable(addr_o) && $stable(beat_o) && $stable(err_o));
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(addr_o) && $stable(beat_o) && !busy_o);
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic [7:0]  len_i = '0;
   logic [2:0]  size_i = '0;
   logic [1:0]  burst_i = '0;
   logic        advance_i = 1'b0;
   logic [31:0] addr_o;
   logic [7:0]  beat_o;
   logic        last_o, busy_o, err_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   burst_addr_gen i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .len_i(len_i), .size_i(size_i), .burst_i(burst_i), .advance_i(advance_i),
      .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic bit exp_bad(longint a, int len, int sz, int bt);
      longint st = longint'(1) << sz;
      longint al = a - (a % st);
      longint last_b = al + longint'(len + 1) * st - 1;
      case (bt)
         0: return 1'b0;
         1: return (last_b >> 12) != (a >> 12);
         2: return !(len == 1 || len == 3 || len == 7 || len == 15);
         default: return 1'b1;
      endcase
   endfunction

   function automatic longint exp_addr(longint a, int len, int sz, int bt, int n);
      longint st = longint'(1) << sz;
      longint al = a - (a % st);
      longint win = longint'(len + 1) * st;
      longint lo = al - (al % win);
      if (n == 0 || bt == 0) return a;
      if (bt == 1) return al + longint'(n) * st;
      return lo + ((al - lo + longint'(n) * st) % win);
   endfunction

   task automatic run_burst(input longint a, input int len, input int sz, input int bt);
      bit bad = exp_bad(a, len, sz, bt);
      logic [31:0] held_a;
      logic [7:0]  held_b;
      start_addr_i = a[31:0];
      len_i = 8'(len);
      size_i = 3'(sz);
      burst_i = 2'(bt);
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      chk(err_o == bad, "R7 err_o verdict", err_o, bad);
      chk(busy_o == !bad, "R2/R7 busy after start", busy_o, !bad);
      if (!bad) begin
         for (int n = 0; n <= len; n++) begin
            longint ea = exp_addr(a, len, sz, bt, n);
            string tg = (bt == 0) ? "R6 fixed addr" : (bt == 1) ? "R4 incr addr" : "R5 wrap addr";
            chk(addr_o == ea[31:0], tg, addr_o, ea[31:0]);
            chk(beat_o == 8'(n), "R2 beat index", beat_o, n);
            chk(last_o == (n == len), "R3 last flag", last_o, n == len);
            chk(busy_o == 1'b1, "R2 busy during burst", busy_o, 1);
            if (n % 5 == 2) begin
               held_a = addr_o;
               held_b = beat_o;
               tick();
               chk(addr_o == held_a && beat_o == held_b, "R9 hold without advance", addr_o, held_a);
            end
            advance_i = 1'b1;
            if (n == len || n == 1) begin
               start_addr_i = a[31:0] ^ 32'h40;
               burst_i = 2'b01;
               len_i = 8'd0;
               start_i = 1'b1;
            end
            tick();
            advance_i = 1'b0;
            start_i = 1'b0;
         end
         chk(busy_o == 1'b0, "R2/R8 busy clears after last", busy_o, 0);
         chk(err_o == 1'b0, "R8 err unchanged", err_o, 0);
         chk(last_o == 1'b0, "R3 last low when idle", last_o, 0);
      end
      held_a = addr_o;
      held_b = beat_o;
      advance_i = 1'b1;
      tick();
      advance_i = 1'b0;
      chk(addr_o == held_a && beat_o == held_b && !busy_o, "R9 idle advance ignored", addr_o, held_a);
      chk(err_o == bad, "R7 err holds", err_o, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int lens[8] = '{0, 1, 3, 7, 15, 16, 100, 255};
      longint addrs[4] = '{64'h0, 64'h0000_0FF3, 64'h1234_5678, 64'hFFFF_FF80};
      repeat (3) tick();
      chk(!busy_o && !err_o && !last_o, "R1 reset flags", {busy_o, err_o, last_o}, 0);
      chk(addr_o == 0 && beat_o == 0, "R1 reset addr/beat", addr_o, 0);
      rst_n = 1'b1;
      tick();
      for (int bt = 0; bt < 4; bt++)
         for (int sz = 0; sz < 8; sz++)
            for (int li = 0; li < 8; li++)
               for (int ai = 0; ai < 4; ai++)
                  run_burst(addrs[ai], lens[li], sz, bt);
      run_burst(64'h0000_0FFC, 0, 2, 1);
      run_burst(64'h0000_0FFC, 1, 2, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule